// File: doc/BRIEF.md
# Set-Associative Address Translation Lookup with Pseudo-Random Refill Way

This block translates a 32-bit virtual address for one address space, either instruction or data. It holds four ways of sixteen entries. Each entry has a tag word and an attribute word. The page size is 8 KiB, so the virtual page number is `lk_vaddr[31:13]`. The low four bits of that page number pick the same slot in every way.

A lookup is purely combinational and completes in the cycle it is presented. The lookup inputs are:

- the address,
- the current 8-bit process identifier,
- the access kind,
- a user-mode flag,
- a debug flag.

The block returns:

- a translation-success flag,
- the physical frame number,
- read, write and execute permissions,
- an exception vector number.

The vector base is 4 in the instruction variant and 8 in the data variant. Four enable bits in a configuration word decide which protection checks apply. When a lookup faults and its debug flag is low, three registers update at the next clock edge:

- A 16-bit replacement shift register advances, and supplies the way that a refill handler should overwrite.
- A selection register records the slot and the way.
- A cause register records the identifier, the access kind and the page number.

A simple write port loads one entry per cycle. Page-table walking and exception entry belong to the surrounding core.

Top module: `tlbx_unit`

## Requirements
- R1: The tag word holds the tag page number in bits 31:13 and the entry identifier in bits 7:0. A way hits when its tag page number equals `lk_vaddr[31:13]` and either the entry's global flag is set or its identifier equals `lk_pid`. The lowest-numbered hitting way is used.
- R2: When `wr_en` is sampled high at a clock edge, the entry at way `wr_way`, slot `wr_idx` is loaded with `wr_hi` and `wr_lo`. The attribute word holds the frame number in bits 31:13, global in bit 4, valid in bit 3, kernel-only in bit 2, writable in bit 1 and executable in bit 0.
- R3: When no way hits, `xl_ok` is 0, all three permissions are 0 and `xl_vec` equals the base (4 when `IS_INSTR`=1, 8 otherwise). The upper two bits of `xl_vec` always equal those of the base.
- R4: After a hit, faults are ranked in this order, and the first that applies sets `xl_ok` to 0:
  1. kernel-only entry with `lk_user`=1 and `cfg[18]`=1 gives base+2;
  2. access kind write (code 1) to a non-writable entry with `cfg[19]`=1 gives base+3;
  3. access kind exec (code 2) to a non-executable entry with `cfg[17]`=1 gives base+3;
  4. entry not valid with `cfg[16]`=1 gives base+1.
- R5: On success, `xl_perm_r`=1 and `xl_perm_w` follows the writable flag. `xl_pfn` is the hitting entry's frame number. `xl_perm_x`=1 only when `IS_INSTR`=1 and either `cfg[17]` or the entry's executable flag is set.
- R6: `rf_lfsr` resets to 0xCCCC. On each clock edge where `lk_valid`=1, `xl_ok`=0 and `lk_debug`=0, it shifts right by one, and its new bit 15 is the parity of (old value AND 0x8805).
- R7: `rf_sel` resets to 0. On a non-debug fault it loads the slot (`lk_vaddr[16:13]`) in bits 3:0 and the way in bits 5:4, and clears all other bits. The way is the hitting way for a protection fault, or `rf_lfsr[1:0]` before the shift for a miss.
- R8: `rf_cause` resets to 0. On a non-debug fault, bits 7:0 take `lk_pid`, bits 9:8 take the access code (read=0, write=1, exec=2) and bits 31:13 take the page number. Its other bits keep their value.
- R9: A lookup with `lk_debug`=1, a successful lookup, or a cycle with `lk_valid`=0 leaves `rf_lfsr`, `rf_sel` and `rf_cause` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 4 | Slot to write |
| wr_hi | input | 32 | Tag word to store |
| wr_lo | input | 32 | Attribute word to store |
| cfg | input | 32 | Configuration word; bits 19:16 enable the checks |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vaddr | input | 32 | Virtual address |
| lk_pid | input | 8 | Current process identifier |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 exec |
| lk_user | input | 1 | Access made from user mode |
| lk_debug | input | 1 | Side-effect-free lookup |
| xl_ok | output | 1 | Translation succeeded |
| xl_pfn | output | 19 | Physical frame number (0 when not successful) |
| xl_perm_r | output | 1 | Read permitted |
| xl_perm_w | output | 1 | Write permitted |
| xl_perm_x | output | 1 | Execute permitted |
| xl_vec | output | 4 | Exception vector number |
| rf_lfsr | output | 16 | Replacement shift register |
| rf_sel | output | 32 | Selection register |
| rf_cause | output | 32 | Cause register |

## Verification
The assertions assume that `lk_acc` never carries code 3. They also assume that the lookup inputs are steady from just after the falling edge until the next rising edge, because the fault registers sample them at that edge. The bench drives every input on the falling edge and uses only codes 0 to 2. It avoids addresses with page number 0 and identifier 0, so the all-zero entries left by reset never produce an unintended hit. A second instance with the instruction base shares all inputs, so the instruction-only execute and vector rules are checked under the same stimulus.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  // access kind codes, also stored in the cause register
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  // attribute word flag positions
  localparam int unsigned AT_GLOBAL = 4;
  localparam int unsigned AT_VALID  = 3;
  localparam int unsigned AT_KERN   = 2;
  localparam int unsigned AT_WRITE  = 1;
  localparam int unsigned AT_EXEC   = 0;

  // configuration word enable positions
  localparam int unsigned CF_WRITE  = 19;
  localparam int unsigned CF_KERN   = 18;
  localparam int unsigned CF_EXEC   = 17;
  localparam int unsigned CF_VALID  = 16;

  // vector offsets from the unit's base
  localparam logic [3:0] VOFF_REFILL  = 4'd0;
  localparam logic [3:0] VOFF_INVALID = 4'd1;
  localparam logic [3:0] VOFF_PRIV    = 4'd2;
  localparam logic [3:0] VOFF_RIGHTS  = 4'd3;

  // cause register placement of the access kind
  localparam int unsigned CAUSE_ACC_LSB = 8;

  typedef struct packed {
    logic glob;
    logic valid;
    logic kern;
    logic wr;
    logic ex;
  } attr_t;

  typedef struct packed {
    logic wr;
    logic kern;
    logic ex;
    logic valid;
  } chk_en_t;
endpackage

// File: rtl/tlbx_rst_sync.sv
module tlbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/tlbx_store.sv
module tlbx_store #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 16,
  parameter int unsigned WORD  = 32,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [WORD-1:0]            wr_hi,
  input  logic [WORD-1:0]            wr_lo,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [WAYS-1:0][WORD-1:0]  rd_hi,
  output logic [WAYS-1:0][WORD-1:0]  rd_lo
);
  logic [WORD-1:0] hi_q [WAYS][SETS];
  logic [WORD-1:0] lo_q [WAYS][SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    for (genvar s = 0; s < SETS; s++) begin : g_slot
      logic load_en;
      assign load_en = wr_en && (wr_way == WAY_W'(w)) && (wr_idx == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_q[w][s] <= '0;
          lo_q[w][s] <= '0;
        end else if (load_en) begin
          hi_q[w][s] <= wr_hi;
          lo_q[w][s] <= wr_lo;
        end
      end
    end

    assign rd_hi[w] = hi_q[w][rd_idx];
    assign rd_lo[w] = lo_q[w][rd_idx];
  end
endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
  import tlbx_pkg::*;
#(
  parameter int unsigned WAYS      = 4,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned PID_W     = 8,
  parameter bit          IS_INSTR  = 1'b0,
  localparam int unsigned WAY_W    = $clog2(WAYS),
  localparam int unsigned VPN_W    = 32 - PAGE_BITS
) (
  input  logic [WAYS-1:0][31:0] rd_hi,
  input  logic [WAYS-1:0][31:0] rd_lo,
  input  logic [VPN_W-1:0]      vpn,
  input  logic [PID_W-1:0]      pid,
  input  acc_e                  acc,
  input  logic                  user,
  input  chk_en_t               chk,
  output logic                  hit_any,
  output logic [WAY_W-1:0]      hit_way,
  output logic                  ok,
  output logic [VPN_W-1:0]      pfn,
  output logic                  perm_r,
  output logic                  perm_w,
  output logic                  perm_x,
  output logic [3:0]            vec
);
  localparam logic [3:0] BASE = IS_INSTR ? 4'd4 : 4'd8;

  logic [WAYS-1:0] way_hit;
  attr_t           attr_w [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic tag_eq;
    logic pid_eq;
    assign attr_w[w] = '{glob:  rd_lo[w][AT_GLOBAL],
                         valid: rd_lo[w][AT_VALID],
                         kern:  rd_lo[w][AT_KERN],
                         wr:    rd_lo[w][AT_WRITE],
                         ex:    rd_lo[w][AT_EXEC]};
    assign tag_eq     = (rd_hi[w][31:PAGE_BITS] == vpn);
    assign pid_eq     = (rd_hi[w][PID_W-1:0] == pid);
    assign way_hit[w] = tag_eq && (attr_w[w].glob || pid_eq);
  end

  // lowest index wins
  always_comb begin
    hit_any = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w] && !hit_any) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  attr_t            sel_attr;
  logic [VPN_W-1:0] sel_pfn;
  always_comb begin
    sel_attr = attr_w[hit_way];
    sel_pfn  = rd_lo[hit_way][31:PAGE_BITS];
  end

  // ranked fault classification
  always_comb begin
    ok  = 1'b0;
    vec = BASE + VOFF_REFILL;
    if (!hit_any) begin
      vec = BASE + VOFF_REFILL;
    end else if (chk.kern && sel_attr.kern && user) begin
      vec = BASE + VOFF_PRIV;
    end else if ((acc == ACC_WRITE) && chk.wr && !sel_attr.wr) begin
      vec = BASE + VOFF_RIGHTS;
    end else if ((acc == ACC_EXEC) && chk.ex && !sel_attr.ex) begin
      vec = BASE + VOFF_RIGHTS;
    end else if (chk.valid && !sel_attr.valid) begin
      vec = BASE + VOFF_INVALID;
    end else begin
      ok  = 1'b1;
      vec = BASE;
    end
  end

  always_comb begin
    perm_r = ok;
    perm_w = ok && sel_attr.wr;
    perm_x = ok && IS_INSTR && (chk.ex || sel_attr.ex);
    pfn    = ok ? sel_pfn : '0;
  end

  logic unused_bits;
  assign unused_bits = ^{rd_hi, rd_lo};
endmodule

// File: rtl/tlbx_lfsr.sv
module tlbx_lfsr #(
  parameter int unsigned    W    = 16,
  parameter logic [W-1:0]   SEED = 16'hCCCC,
  parameter logic [W-1:0]   TAPS = 16'h8805
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q;
    if (step) begin
      state_d = {^(state_q & TAPS), state_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/tlbx_unit.sv
module tlbx_unit
  import tlbx_pkg::*;
#(
  parameter int unsigned WAYS      = 4,
  parameter int unsigned SETS      = 16,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned PID_W     = 8,
  parameter int unsigned RND_W     = 16,
  parameter bit          IS_INSTR  = 1'b0,
  localparam int unsigned IDX_W    = $clog2(SETS),
  localparam int unsigned WAY_W    = $clog2(WAYS),
  localparam int unsigned VPN_W    = 32 - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_hi,
  input  logic [31:0]      wr_lo,
  input  logic [31:0]      cfg,
  input  logic             lk_valid,
  input  logic [31:0]      lk_vaddr,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [1:0]       lk_acc,
  input  logic             lk_user,
  input  logic             lk_debug,
  output logic             xl_ok,
  output logic [VPN_W-1:0] xl_pfn,
  output logic             xl_perm_r,
  output logic             xl_perm_w,
  output logic             xl_perm_x,
  output logic [3:0]       xl_vec,
  output logic [RND_W-1:0] rf_lfsr,
  output logic [31:0]      rf_sel,
  output logic [31:0]      rf_cause
);
  logic rst_sn;
  tlbx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_sn));

  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] idx;
  assign vpn = lk_vaddr[31:PAGE_BITS];
  assign idx = vpn[IDX_W-1:0];

  logic [WAYS-1:0][31:0] rd_hi;
  logic [WAYS-1:0][31:0] rd_lo;

  tlbx_store #(.WAYS(WAYS), .SETS(SETS), .WORD(32)) u_store (
    .clk(clk), .rst_n(rst_sn),
    .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_hi(wr_hi), .wr_lo(wr_lo),
    .rd_idx(idx), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  chk_en_t chk;
  assign chk = '{wr: cfg[CF_WRITE], kern: cfg[CF_KERN],
                 ex: cfg[CF_EXEC],  valid: cfg[CF_VALID]};

  logic             hit_any;
  logic [WAY_W-1:0] hit_way;

  tlbx_match #(.WAYS(WAYS), .PAGE_BITS(PAGE_BITS), .PID_W(PID_W),
               .IS_INSTR(IS_INSTR)) u_match (
    .rd_hi(rd_hi), .rd_lo(rd_lo), .vpn(vpn), .pid(lk_pid),
    .acc(acc_e'(lk_acc)), .user(lk_user), .chk(chk),
    .hit_any(hit_any), .hit_way(hit_way), .ok(xl_ok), .pfn(xl_pfn),
    .perm_r(xl_perm_r), .perm_w(xl_perm_w), .perm_x(xl_perm_x),
    .vec(xl_vec)
  );

  logic fault_ev;
  assign fault_ev = lk_valid && !xl_ok && !lk_debug;

  tlbx_lfsr #(.W(RND_W)) u_rnd (
    .clk(clk), .rst_n(rst_sn), .step(fault_ev), .state(rf_lfsr)
  );

  // fault capture registers
  logic [31:0] sel_q, sel_d;
  logic [31:0] cause_q, cause_d;

  always_comb begin
    sel_d                  = '0;
    sel_d[IDX_W-1:0]       = idx;
    sel_d[IDX_W +: WAY_W]  = hit_any ? hit_way : rf_lfsr[WAY_W-1:0];
  end

  always_comb begin
    cause_d                       = cause_q;
    cause_d[PID_W-1:0]            = lk_pid;
    cause_d[CAUSE_ACC_LSB +: 2]   = lk_acc;
    cause_d[31:PAGE_BITS]         = vpn;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sel_q   <= '0;
      cause_q <= '0;
    end else if (fault_ev) begin
      sel_q   <= sel_d;
      cause_q <= cause_d;
    end
  end

  assign rf_sel   = sel_q;
  assign rf_cause = cause_q;

  logic unused_cfg;
  assign unused_cfg = ^{cfg[31:20], cfg[15:0], lk_vaddr[PAGE_BITS-1:0]};
endmodule

// File: rtl/tlbx_unit_chk.sv
module tlbx_unit_chk #(
  parameter bit          IS_INSTR = 1'b0,
  parameter int unsigned USED_W   = 6,
  parameter int unsigned PID_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_debug,
  input logic [PID_W-1:0] lk_pid,
  input logic [1:0]       lk_acc,
  input logic             xl_ok,
  input logic             xl_perm_r,
  input logic             xl_perm_w,
  input logic             xl_perm_x,
  input logic [3:0]       xl_vec,
  input logic [15:0]      rf_lfsr,
  input logic [31:0]      rf_sel,
  input logic [31:0]      rf_cause
);
  localparam logic [1:0] BASE_HI = IS_INSTR ? 2'b01 : 2'b10;

  p_vec_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xl_vec[3:2] == BASE_HI);

  p_fail_noperm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_ok |-> !(xl_perm_r || xl_perm_w || xl_perm_x));

  p_ok_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xl_ok |-> xl_perm_r);

  p_data_noexec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !IS_INSTR |-> !xl_perm_x);

  p_lfsr_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !xl_ok && !lk_debug) |=> rf_lfsr[14:0] == $past(rf_lfsr[15:1]));

  p_sel_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_sel[31:USED_W] == '0);

  p_cause_pid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !xl_ok && !lk_debug) |=>
      rf_cause[PID_W-1:0] == $past(lk_pid) && rf_cause[9:8] == $past(lk_acc));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && !xl_ok && !lk_debug) |=>
      $stable(rf_lfsr) && $stable(rf_sel) && $stable(rf_cause));
endmodule

bind tlbx_unit tlbx_unit_chk #(.IS_INSTR(IS_INSTR), .USED_W(IDX_W + WAY_W),
                               .PID_W(PID_W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .lk_valid(lk_valid), .lk_debug(lk_debug),
  .lk_pid(lk_pid), .lk_acc(lk_acc), .xl_ok(xl_ok), .xl_perm_r(xl_perm_r),
  .xl_perm_w(xl_perm_w), .xl_perm_x(xl_perm_x), .xl_vec(xl_vec),
  .rf_lfsr(rf_lfsr), .rf_sel(rf_sel), .rf_cause(rf_cause)
);

// File: tb/tb_tlbx_unit.sv
`timescale 1ns/1ps
module tb_tlbx_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_way;
  logic [3:0]  wr_idx;
  logic [31:0] wr_hi, wr_lo, cfg;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_pid;
  logic [1:0]  lk_acc;
  logic        lk_user, lk_debug;

  logic        ok, pr, pw, px;
  logic [18:0] pfn;
  logic [3:0]  vec;
  logic [15:0] lfsr;
  logic [31:0] sel, cause;

  logic        ok_i, pr_i, pw_i, px_i;
  logic [18:0] pfn_i;
  logic [3:0]  vec_i;
  logic [15:0] lfsr_i;
  logic [31:0] sel_i, cause_i;

  always #2.5 clk = ~clk;

  tlbx_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .cfg(cfg), .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_acc(lk_acc), .lk_user(lk_user),
    .lk_debug(lk_debug), .xl_ok(ok), .xl_pfn(pfn), .xl_perm_r(pr),
    .xl_perm_w(pw), .xl_perm_x(px), .xl_vec(vec), .rf_lfsr(lfsr),
    .rf_sel(sel), .rf_cause(cause)
  );

  tlbx_unit #(.IS_INSTR(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .cfg(cfg), .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_acc(lk_acc), .lk_user(lk_user),
    .lk_debug(lk_debug), .xl_ok(ok_i), .xl_pfn(pfn_i), .xl_perm_r(pr_i),
    .xl_perm_w(pw_i), .xl_perm_x(px_i), .xl_vec(vec_i), .rf_lfsr(lfsr_i),
    .rf_sel(sel_i), .rf_cause(cause_i)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [15:0] m_lfsr;

  localparam logic [18:0] VA = 19'h12345;  // slot 5
  localparam logic [18:0] VB = 19'h00007;  // slot 7
  localparam logic [18:0] VC = 19'h00AB9;  // slot 9

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] x);
    return {^(x & 16'h8805), x[15:1]};
  endfunction

  function automatic logic [31:0] mk_hi(input logic [18:0] v, input logic [7:0] p);
    return {v, 5'b0, p};
  endfunction

  function automatic logic [31:0] mk_lo(input logic [18:0] f, input logic g, v, k, w, x);
    return {f, 8'b0, g, v, k, w, x};
  endfunction

  task automatic wr(input logic [1:0] way, input logic [3:0] ix,
                    input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    wr_en = 1'b1; wr_way = way; wr_idx = ix; wr_hi = hi; wr_lo = lo;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // present one lookup, check ok/vec, then check fault registers a cycle later
  // hit_way < 0 means an expected miss
  task automatic look(input string req, input logic [18:0] v, input logic [7:0] p,
                      input logic [1:0] acc, input logic usr, input logic dbg,
                      input logic exp_ok, input logic [3:0] exp_vec, input int hit_way);
    logic [15:0] s_lfsr;
    logic [31:0] s_sel, s_cause, e_sel, e_cause;
    @(negedge clk);
    s_lfsr = lfsr; s_sel = sel; s_cause = cause;
    lk_valid = 1'b1; lk_vaddr = {v, 13'h0A5}; lk_pid = p; lk_acc = acc;
    lk_user = usr; lk_debug = dbg;
    #1;
    chk({req, " ok"}, 32'(ok), 32'(exp_ok));
    chk({req, " vec"}, 32'(vec), 32'(exp_vec));
    @(negedge clk);
    lk_valid = 1'b0;
    #1;
    if (!exp_ok && !dbg) begin
      e_sel = 32'h0;
      e_sel[3:0] = v[3:0];
      e_sel[5:4] = (hit_way < 0) ? m_lfsr[1:0] : 2'(hit_way);
      e_cause = s_cause;
      e_cause[7:0] = p; e_cause[9:8] = acc; e_cause[31:13] = v;
      m_lfsr = lfsr_next(m_lfsr);
      chk({req, " R6 lfsr"}, 32'(lfsr), 32'(m_lfsr));
      chk({req, " R7 sel"}, sel, e_sel);
      chk({req, " R8 cause"}, cause, e_cause);
    end else begin
      chk({req, " R9 lfsr hold"}, 32'(lfsr), 32'(s_lfsr));
      chk({req, " R9 sel hold"}, sel, s_sel);
      chk({req, " R9 cause hold"}, cause, s_cause);
    end
  endtask

  task automatic t_reset;
    chk("R6 reset lfsr", 32'(lfsr), 32'hCCCC);
    chk("R7 reset sel", sel, 32'h0);
    chk("R8 reset cause", cause, 32'h0);
  endtask

  task automatic t_hit;
    cfg = 32'h0;
    wr(2'd2, 4'd5, mk_hi(VA, 8'h33), mk_lo(19'h00ABC, 0, 1, 0, 1, 0));
    look("R1 R2 pid hit", VA, 8'h33, 2'd0, 0, 0, 1, 4'd8, 2);
    chk("R5 pfn", 32'(pfn), 32'h00ABC);
    chk("R5 perm r", 32'(pr), 1);
    chk("R5 perm w", 32'(pw), 1);
    chk("R5 data perm x", 32'(px), 0);
    chk("R5 instr perm x off", 32'(px_i), 0);
  endtask

  task automatic t_miss;
    look("R3 pid miss", VA, 8'h34, 2'd0, 0, 0, 0, 4'd8, -1);
    chk("R3 instr refill vec", 32'(vec_i), 32'd4);
    chk("R3 miss perms", 32'({pr, pw, px}), 0);
    chk("R3 miss pfn", 32'(pfn), 0);
    look("R3 R7 tag miss write", VB, 8'h33, 2'd1, 0, 0, 0, 4'd8, -1);
    look("R3 R7 tag miss exec", VB, 8'h10, 2'd2, 1, 0, 0, 4'd8, -1);
  endtask

  task automatic t_global;
    wr(2'd1, 4'd5, mk_hi(VA, 8'h99), mk_lo(19'h11111, 1, 1, 0, 0, 0));
    look("R1 lowest way wins", VA, 8'h33, 2'd0, 0, 0, 1, 4'd8, 1);
    chk("R1 lowest way pfn", 32'(pfn), 32'h11111);
    chk("R5 perm w follows entry", 32'(pw), 0);
    look("R1 global any pid", VA, 8'h50, 2'd0, 0, 0, 1, 4'd8, 1);
    chk("R1 global pfn", 32'(pfn), 32'h11111);
  endtask

  task automatic t_prio;
    wr(2'd3, 4'd9, mk_hi(VC, 8'h21), mk_lo(19'h02222, 0, 0, 1, 0, 0));
    cfg = 32'h000F_0000;
    look("R4 kernel first", VC, 8'h21, 2'd1, 1, 0, 0, 4'd10, 3);
    look("R4 write second", VC, 8'h21, 2'd1, 0, 0, 0, 4'd11, 3);
    look("R4 exec third", VC, 8'h21, 2'd2, 0, 0, 0, 4'd11, 3);
    chk("R4 instr exec vec", 32'(vec_i), 32'd7);
    look("R4 invalid last", VC, 8'h21, 2'd0, 0, 0, 0, 4'd9, 3);
    cfg = 32'h0007_0000;
    look("R4 write check off", VC, 8'h21, 2'd1, 0, 0, 0, 4'd9, 3);
    cfg = 32'h0;
    look("R4 all checks off", VC, 8'h21, 2'd1, 1, 0, 1, 4'd8, 3);
    chk("R5 pfn c", 32'(pfn), 32'h02222);
    chk("R5 no write perm", 32'(pw), 0);
  endtask

  task automatic t_debug;
    look("R9 debug miss", VB, 8'h33, 2'd0, 0, 1, 0, 4'd8, -1);
    cfg = 32'h000F_0000;
    look("R9 debug fault", VC, 8'h21, 2'd1, 1, 1, 0, 4'd10, 3);
    cfg = 32'h0;
  endtask

  task automatic t_exec;
    cfg = 32'h0002_0000;
    look("R5 exec by cfg", VC, 8'h21, 2'd0, 0, 0, 1, 4'd8, 3);
    chk("R5 instr x via cfg", 32'(px_i), 1);
    chk("R5 data x never", 32'(px), 0);
    cfg = 32'h0;
    wr(2'd3, 4'd9, mk_hi(VC, 8'h21), mk_lo(19'h02222, 0, 1, 0, 1, 1));
    look("R2 rewrite entry", VC, 8'h21, 2'd0, 0, 0, 1, 4'd8, 3);
    chk("R5 instr x via entry", 32'(px_i), 1);
    chk("R2 rewritten w", 32'(pw), 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_way = '0; wr_idx = '0; wr_hi = '0; wr_lo = '0;
    cfg = '0; lk_valid = 1'b0; lk_vaddr = '0; lk_pid = '0; lk_acc = '0;
    lk_user = 1'b0; lk_debug = 1'b0;
    m_lfsr = 16'hCCCC;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hit();
    t_miss();
    t_global();
    t_prio();
    t_debug();
    t_exec();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule